// File: doc/BRIEF.md
# Memory Dependence Wakeup Table

This table holds in-flight memory instructions and decides when each may be issued. At insert, every instruction is given a count of the older producers it must wait for. Producers are either outstanding barriers, which the barrier tracker reports as entry masks, or a single conflicting store named by sequence number by an external predictor. Only producers that still sit in the table are counted. Each producer row keeps a bit-vector of the entries that wait on it. When that producer completes, every marked dependent is decremented in the same cycle and the producer's slot is freed.

An entry becomes issuable once its count is zero, its source registers are ready, and it has not been squashed. Issuable entries queue in a pending vector. The lowest pending index is presented on `issue_valid`/`issue_idx` for exactly one cycle. Inserts use a valid/ready handshake. `ins_ready` is high while at least one slot is free, and an insert is taken only on a cycle where both `ins_valid` and `ins_ready` are high. The slot it receives is shown on `ins_idx` during that cycle. The completion, register-ready and squash inputs are plain single-cycle strobes with no back-pressure. A squash must cover every surviving dependent of a squashed producer, because squashing a producer does not decrement its dependents.

Top module: `mdw_table`

## Requirements
- R1: `ins_ready` is high exactly when a slot is free, and `ins_idx` then shows the lowest free slot. An insert is accepted only when `ins_valid` and `ins_ready` are both high; with `ins_ready` low, `ins_valid` changes no state.
- R2: A load (`ins_kind`=0) or atomic (`ins_kind`=2) whose `ins_ld_bar` mask is nonzero depends on every entry in that mask.
- R3: Otherwise, a store (`ins_kind`=1) or atomic whose `ins_st_bar` mask is nonzero depends on every entry in that mask. `ins_kind`=3 never uses either barrier mask.
- R4: Otherwise, the instruction depends on the entry whose stored sequence number equals `ins_pred_seq`. A value of zero names no producer.
- R5: Only valid producers are counted, and a producer that is being completed or squashed in the same cycle is not counted. The count is set to the number of producers found.
- R6: An entry inserted with a count of zero and `ins_regs_rdy` high becomes pending at the accepting edge.
- R7: A `done_valid` on entry `done_idx` frees that entry and decrements the count of each of its dependents. A dependent becomes pending when its count reaches zero and its registers are ready.
- R8: A `rr_valid` event marks the registers of entry `rr_idx` ready. The entry becomes pending only if its count is zero at that point.
- R9: `conflict_loads` increments by one for each accepted load that receives at least one dependency.
- R10: Entries set in `squash_mask` are freed and lose any pending issue. Their bits are removed from every producer's dependent list, so a later completion of that producer leaves a reused slot untouched.
- R11: The lowest pending index is shown while `issue_valid` is high. It leaves the pending set at the next edge, so several pending entries issue one per cycle in ascending index order.
- R12: `dep_err` pulses if a completion would decrement a count that is already zero. It stays low under legal use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | A slot is free |
| ins_kind | input | 2 | 0 load, 1 store, 2 atomic, 3 other |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_pred_seq | input | SEQ_W | Predicted producer sequence number, 0 for none |
| ins_ld_bar | input | N | Entries that are outstanding load barriers |
| ins_st_bar | input | N | Entries that are outstanding store barriers |
| ins_regs_rdy | input | 1 | Source registers already ready at insert |
| ins_idx | output | IDX_W | Slot taken by an accepted insert |
| rr_valid | input | 1 | Register-ready event |
| rr_idx | input | IDX_W | Entry whose registers became ready |
| done_valid | input | 1 | Producer completion |
| done_idx | input | IDX_W | Completing entry |
| squash_mask | input | N | Entries to squash |
| issue_valid | output | 1 | Issue pulse |
| issue_idx | output | IDX_W | Entry allowed to issue |
| conflict_loads | output | STAT_W | Count of loads that received dependencies |
| dep_err | output | 1 | Count underflow seen |

## Verification
`ins_ready`, `ins_idx` and `dep_err` follow the table state without delay. Every insert, completion, register-ready or squash takes effect at the next rising edge. An entry made pending at that edge is therefore shown on `issue_valid`/`issue_idx` in the cycle right after the stimulus, and `conflict_loads` steps at the same edge. The bench applies its inputs at the falling edge and compares all outputs at the next falling edge against a reference model, advanced once per rising edge. Each result is thus checked in the first cycle in which it is due, with no tolerance window.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  typedef enum logic [1:0] {
    MK_LOAD   = 2'd0,
    MK_STORE  = 2'd1,
    MK_ATOMIC = 2'd2,
    MK_OTHER  = 2'd3
  } mem_kind_e;
endpackage

// File: rtl/mdw_lowest.sv
// Lowest-index pick over a request vector.
module mdw_lowest #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/mdw_prod_sel.sv
// Chooses the producer set of an inserted instruction and counts it.
module mdw_prod_sel
  import mdw_pkg::*;
#(
  parameter int N     = 8,
  parameter int SEQ_W = 16,
  localparam int CW   = $clog2(N + 1)
) (
  input  logic [1:0]                kind,
  input  logic [N-1:0]              ld_bar,
  input  logic [N-1:0]              st_bar,
  input  logic [SEQ_W-1:0]          pred_seq,
  input  logic [N-1:0]              present,
  input  logic [N-1:0][SEQ_W-1:0]   seq_tab,
  output logic [N-1:0]              prod_mask,
  output logic [CW-1:0]             prod_cnt
);
  mem_kind_e  k;
  logic       wants_ld, wants_st;
  logic [N-1:0] pred_hit, cand;

  assign k        = mem_kind_e'(kind);
  assign wants_ld = (k == MK_LOAD) || (k == MK_ATOMIC);
  assign wants_st = (k == MK_STORE) || (k == MK_ATOMIC);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pred_hit[i] = (pred_seq != '0) && (seq_tab[i] == pred_seq);
    end
  end

  always_comb begin
    if (wants_ld && (|ld_bar))      cand = ld_bar;
    else if (wants_st && (|st_bar)) cand = st_bar;
    else                            cand = pred_hit;
  end

  assign prod_mask = cand & present;

  always_comb begin
    prod_cnt = '0;
    for (int i = 0; i < N; i++) prod_cnt = prod_cnt + CW'(prod_mask[i]);
  end
endmodule

// File: rtl/mdw_entry.sv
// One table slot: wait count, register state, issue state and dependent list.
module mdw_entry #(
  parameter int N     = 8,
  parameter int SEQ_W = 16,
  localparam int CW   = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [SEQ_W-1:0] init_seq,
  input  logic [CW-1:0]    init_cnt,
  input  logic             init_rr,
  input  logic             dec,
  input  logic             rr_set,
  input  logic             kill,
  input  logic             take,
  input  logic [N-1:0]     dep_add,
  input  logic [N-1:0]     dep_clr,
  output logic             valid_q,
  output logic [SEQ_W-1:0] seq_q,
  output logic [CW-1:0]    cnt_q,
  output logic             pend_q,
  output logic [N-1:0]     deps_q,
  output logic             underflow
);
  logic          rr_q, fired_q;
  logic [CW-1:0] cnt_n;
  logic          rr_n, fired_b, fire_now;

  always_comb begin
    cnt_n = cnt_q;
    if (alloc)                   cnt_n = init_cnt;
    else if (dec && cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  assign rr_n      = alloc ? init_rr : (rr_q | rr_set);
  assign fired_b   = alloc ? 1'b0 : fired_q;
  assign fire_now  = (alloc | valid_q) & ~kill & ~fired_b & (cnt_n == '0) & rr_n;
  assign underflow = valid_q & ~alloc & dec & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      seq_q   <= '0;
      cnt_q   <= '0;
      rr_q    <= 1'b0;
      fired_q <= 1'b0;
      pend_q  <= 1'b0;
      deps_q  <= '0;
    end else begin
      if (alloc) seq_q <= init_seq;
      if (kill) begin
        valid_q <= 1'b0;
        cnt_q   <= '0;
        rr_q    <= 1'b0;
        fired_q <= 1'b0;
        pend_q  <= 1'b0;
        deps_q  <= '0;
      end else begin
        valid_q <= valid_q | alloc;
        cnt_q   <= cnt_n;
        rr_q    <= rr_n;
        fired_q <= fired_b | fire_now;
        pend_q  <= (alloc ? 1'b0 : (pend_q & ~take)) | fire_now;
        deps_q  <= alloc ? '0 : ((deps_q & ~dep_clr) | dep_add);
      end
    end
  end
endmodule

// File: rtl/mdw_table.sv
module mdw_table
  import mdw_pkg::*;
#(
  parameter int N      = 8,
  parameter int SEQ_W  = 16,
  parameter int STAT_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [1:0]        ins_kind,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [SEQ_W-1:0]  ins_pred_seq,
  input  logic [N-1:0]      ins_ld_bar,
  input  logic [N-1:0]      ins_st_bar,
  input  logic              ins_regs_rdy,
  output logic [IDX_W-1:0]  ins_idx,
  input  logic              rr_valid,
  input  logic [IDX_W-1:0]  rr_idx,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic [N-1:0]      squash_mask,
  output logic              issue_valid,
  output logic [IDX_W-1:0]  issue_idx,
  output logic [STAT_W-1:0] conflict_loads,
  output logic              dep_err
);
  logic [N-1:0]            entry_valid, entry_pend, entry_uf;
  logic [N-1:0][SEQ_W-1:0] entry_seq;
  logic [N-1:0][CW-1:0]    entry_cnt;
  logic [N-1:0][N-1:0]     entry_deps;
  logic [N-1:0]            done_oh, kill, present, dec_vec, new_oh, take_oh;
  logic [N-1:0]            prod_mask;
  logic [CW-1:0]           prod_cnt;
  logic                    ins_fire;

  mdw_lowest #(.N(N)) u_free_pick (
    .req(~entry_valid), .any(ins_ready), .idx(ins_idx)
  );

  mdw_lowest #(.N(N)) u_issue_pick (
    .req(entry_pend), .any(issue_valid), .idx(issue_idx)
  );

  assign ins_fire = ins_valid & ins_ready;
  assign new_oh   = ins_fire ? (N'(1) << ins_idx) : '0;
  assign take_oh  = issue_valid ? (N'(1) << issue_idx) : '0;
  assign done_oh  = done_valid ? ((N'(1) << done_idx) & entry_valid) : '0;
  assign kill     = done_oh | (squash_mask & entry_valid);
  assign present  = entry_valid & ~kill;
  assign dec_vec  = done_valid ? entry_deps[done_idx] : '0;

  mdw_prod_sel #(.N(N), .SEQ_W(SEQ_W)) u_sel (
    .kind(ins_kind), .ld_bar(ins_ld_bar), .st_bar(ins_st_bar),
    .pred_seq(ins_pred_seq), .present(present), .seq_tab(entry_seq),
    .prod_mask(prod_mask), .prod_cnt(prod_cnt)
  );

  for (genvar g = 0; g < N; g++) begin : g_ent
    mdw_entry #(.N(N), .SEQ_W(SEQ_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(new_oh[g]),
      .init_seq(ins_seq),
      .init_cnt(prod_cnt),
      .init_rr(ins_regs_rdy),
      .dec(dec_vec[g]),
      .rr_set(rr_valid && (rr_idx == IDX_W'(g)) && entry_valid[g]),
      .kill(kill[g]),
      .take(take_oh[g]),
      .dep_add((ins_fire && prod_mask[g]) ? new_oh : '0),
      .dep_clr(kill),
      .valid_q(entry_valid[g]),
      .seq_q(entry_seq[g]),
      .cnt_q(entry_cnt[g]),
      .pend_q(entry_pend[g]),
      .deps_q(entry_deps[g]),
      .underflow(entry_uf[g])
    );
  end

  assign dep_err = |entry_uf;

  always_ff @(posedge clk) begin
    if (!rst_n) conflict_loads <= '0;
    else if (ins_fire && (mem_kind_e'(ins_kind) == MK_LOAD) && (prod_cnt != '0))
      conflict_loads <= conflict_loads + 1'b1;
  end
endmodule

// File: rtl/mdw_table_chk.sv
module mdw_table_chk #(
  parameter int N      = 8,
  parameter int STAT_W = 16,
  parameter int IDX_W  = 3,
  parameter int CW     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ins_fire,
  input logic [IDX_W-1:0]     ins_idx,
  input logic                 issue_valid,
  input logic [IDX_W-1:0]     issue_idx,
  input logic [N-1:0]         entry_valid,
  input logic [N-1:0][CW-1:0] entry_cnt,
  input logic [STAT_W-1:0]    conflict_loads,
  input logic                 dep_err
);
  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |-> !entry_valid[ins_idx]);

  assert_alloc_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> entry_valid[$past(ins_idx)]);

  assert_issue_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (entry_valid[issue_idx] && entry_cnt[issue_idx] == '0));

  assert_conflict_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_loads == $past(conflict_loads)) ||
    (conflict_loads == $past(conflict_loads) + 1'b1));

  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dep_err);
endmodule

bind mdw_table mdw_table_chk #(.N(N), .STAT_W(STAT_W), .IDX_W(IDX_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_fire(ins_fire), .ins_idx(ins_idx),
  .issue_valid(issue_valid), .issue_idx(issue_idx), .entry_valid(entry_valid),
  .entry_cnt(entry_cnt), .conflict_loads(conflict_loads), .dep_err(dep_err)
);

// File: tb/mdw_table_bench.sv
module mdw_table_bench;
  localparam int N = 8;
  localparam int SW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, ins_regs_rdy = 0, rr_valid = 0, done_valid = 0;
  logic [1:0] ins_kind = 0;
  logic [SW-1:0] ins_seq = 0, ins_pred_seq = 0;
  logic [N-1:0] ins_ld_bar = 0, ins_st_bar = 0, squash_mask = 0;
  logic [IW-1:0] rr_idx = 0, done_idx = 0;
  logic ins_ready, issue_valid, dep_err;
  logic [IW-1:0] ins_idx, issue_idx;
  logic [15:0] conflict_loads;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mdw_table u_mdw_table (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_kind(ins_kind), .ins_seq(ins_seq), .ins_pred_seq(ins_pred_seq),
    .ins_ld_bar(ins_ld_bar), .ins_st_bar(ins_st_bar), .ins_regs_rdy(ins_regs_rdy),
    .ins_idx(ins_idx), .rr_valid(rr_valid), .rr_idx(rr_idx),
    .done_valid(done_valid), .done_idx(done_idx), .squash_mask(squash_mask),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .conflict_loads(conflict_loads), .dep_err(dep_err)
  );

  // reference state
  bit [N-1:0] m_valid, m_rr, m_fired, m_pend;
  int m_seq [N];
  int m_cnt [N];
  bit [N-1:0] m_deps [N];
  int m_conf;
  int seq_ctr = 1;

  function automatic int m_lowest(bit [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int m_free();
    return m_lowest(~m_valid);
  endfunction

  task automatic m_reset();
    m_valid = 0; m_rr = 0; m_fired = 0; m_pend = 0; m_conf = 0;
    for (int i = 0; i < N; i++) begin m_seq[i] = 0; m_cnt[i] = 0; m_deps[i] = 0; end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit rdy = ~&m_valid;
    chk(tag, "ins_ready", ins_ready, rdy);
    if (rdy) chk(tag, "ins_idx", ins_idx, m_free());
    chk(tag, "issue_valid", issue_valid, |m_pend);
    if (|m_pend) chk(tag, "issue_idx", issue_idx, m_lowest(m_pend));
    chk(tag, "conflict_loads", conflict_loads, m_conf);
    chk("R12", "dep_err", dep_err, 0);
  endtask

  task automatic m_step();
    bit fire = ins_valid && (~&m_valid);
    int nidx = m_free();
    bit [N-1:0] kill, present, cand, mask, dec, take;
    bit wl, ws;
    int c;
    bit [N-1:0] n_valid, n_rr, n_fired, n_pend;
    int n_cnt [N];
    bit [N-1:0] n_deps [N];
    kill = squash_mask & m_valid;
    if (done_valid && m_valid[done_idx]) kill[done_idx] = 1;
    present = m_valid & ~kill;
    wl = (ins_kind == 0) || (ins_kind == 2);
    ws = (ins_kind == 1) || (ins_kind == 2);
    if (wl && |ins_ld_bar) cand = ins_ld_bar;
    else if (ws && |ins_st_bar) cand = ins_st_bar;
    else begin
      cand = 0;
      for (int i = 0; i < N; i++)
        if (ins_pred_seq != 0 && m_valid[i] && m_seq[i] == ins_pred_seq) cand[i] = 1;
    end
    mask = cand & present;
    c = $countones(mask);
    dec = done_valid ? m_deps[done_idx] : '0;
    take = 0;
    if (|m_pend) take[m_lowest(m_pend)] = 1;
    for (int i = 0; i < N; i++) begin
      bit al = fire && (i == nidx);
      bit fb, fn, rn;
      int cn;
      cn = al ? c : ((dec[i] && m_cnt[i] != 0) ? m_cnt[i] - 1 : m_cnt[i]);
      rn = al ? ins_regs_rdy : (m_rr[i] | (rr_valid && rr_idx == i && m_valid[i]));
      fb = al ? 0 : m_fired[i];
      fn = (al | m_valid[i]) && !kill[i] && !fb && cn == 0 && rn;
      if (kill[i]) begin
        n_valid[i] = 0; n_cnt[i] = 0; n_rr[i] = 0; n_fired[i] = 0; n_pend[i] = 0; n_deps[i] = 0;
      end else begin
        n_valid[i] = m_valid[i] | al; n_cnt[i] = cn; n_rr[i] = rn; n_fired[i] = fb | fn;
        n_pend[i] = (al ? 0 : (m_pend[i] & ~take[i])) | fn;
        n_deps[i] = al ? '0 : (m_deps[i] & ~kill);
        if (fire && mask[i]) n_deps[i][nidx] = 1;
      end
    end
    if (fire) m_seq[nidx] = ins_seq;
    if (fire && ins_kind == 0 && c != 0) m_conf++;
    m_valid = n_valid; m_rr = n_rr; m_fired = n_fired; m_pend = n_pend;
    for (int i = 0; i < N; i++) begin m_cnt[i] = n_cnt[i]; m_deps[i] = n_deps[i]; end
  endtask

  task automatic idle_inputs();
    ins_valid = 0; ins_kind = 0; ins_seq = 0; ins_pred_seq = 0; ins_ld_bar = 0;
    ins_st_bar = 0; ins_regs_rdy = 0; rr_valid = 0; rr_idx = 0; done_valid = 0;
    done_idx = 0; squash_mask = 0;
  endtask

  // inputs already driven at a falling edge; check, advance model, cross the edge
  task automatic tick(string tag);
    compare(tag);
    m_step();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_ins(string tag, int kind, int pred, bit [N-1:0] lb, bit [N-1:0] sb,
                        bit rr, output int idx);
    idx = m_free();
    ins_valid = 1; ins_kind = 2'(kind); ins_seq = SW'(seq_ctr); ins_pred_seq = SW'(pred);
    ins_ld_bar = lb; ins_st_bar = sb; ins_regs_rdy = rr;
    seq_ctr++;
    if (seq_ctr >= 65535) seq_ctr = 1;
    tick(tag);
  endtask

  task automatic do_done(string tag, int idx);
    done_valid = 1; done_idx = IW'(idx); tick(tag);
  endtask

  task automatic do_idle(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic flush(string tag);
    squash_mask = m_valid; tick(tag); do_idle(tag, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int a, b, c, d, e;
    m_reset();
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare("R1");  // reset state

    // R6: no producers, registers ready -> pending at once
    do_ins("R6", 0, 0, 0, 0, 1, a);
    chk("R6", "issue_valid", issue_valid, 1);
    chk("R6", "issue_idx", issue_idx, a);
    do_idle("R6", 1);
    flush("R6");

    // R2 / R7 / R9: load waits on two barriers
    do_ins("R2", 3, 0, 0, 0, 1, a);
    do_ins("R2", 3, 0, 0, 0, 1, b);
    do_idle("R2", 2);
    do_ins("R2", 0, 0, (N'(1) << a) | (N'(1) << b), 0, 1, c);
    chk("R9", "conflict_loads", conflict_loads, 1);
    do_done("R7", a);
    chk("R7", "issue_valid", issue_valid, 0);
    do_done("R7", b);
    chk("R7", "issue_idx", issue_idx, c);
    do_idle("R7", 1);
    flush("R7");

    // R3: store ignores load-barrier mask, uses store mask; kind 3 uses neither
    do_ins("R3", 3, 0, 0, 0, 0, a);
    do_ins("R3", 3, 0, 0, 0, 0, b);
    do_ins("R3", 1, 0, N'(1) << a, N'(1) << b, 1, c);
    do_ins("R3", 3, 0, N'(1) << a, N'(1) << b, 1, d);
    chk("R3", "issue_idx", issue_idx, d);
    do_idle("R3", 1);
    do_done("R3", b);
    chk("R3", "issue_idx", issue_idx, c);
    do_idle("R3", 1);
    flush("R3");

    // R4: predicted producer by sequence number; zero means none
    do_ins("R4", 1, 0, 0, 0, 0, a);
    e = seq_ctr - 1;
    do_ins("R4", 0, e, 0, 0, 1, b);
    chk("R4", "issue_valid", issue_valid, 0);
    do_ins("R4", 0, 0, 0, 0, 1, c);
    chk("R4", "issue_idx", issue_idx, c);
    do_done("R4", a);
    chk("R4", "issue_idx", issue_idx, b);
    do_idle("R4", 1);
    flush("R4");

    // R5: producer completing in the insert cycle is not counted; absent bits ignored
    do_ins("R5", 3, 0, 0, 0, 0, a);
    done_valid = 1; done_idx = IW'(a);
    do_ins("R5", 0, 0, (N'(1) << a) | (N'(1) << 6), 0, 1, b);
    chk("R5", "issue_idx", issue_idx, b);
    do_idle("R5", 1);
    flush("R5");

    // R8: register-ready event only issues with zero count
    do_ins("R8", 3, 0, 0, 0, 0, a);
    do_ins("R8", 0, 0, 0, 0, 0, b);
    do_ins("R8", 0, 0, N'(1) << a, 0, 0, c);
    rr_valid = 1; rr_idx = IW'(c); tick("R8");
    chk("R8", "issue_valid", issue_valid, 0);
    rr_valid = 1; rr_idx = IW'(b); tick("R8");
    chk("R8", "issue_idx", issue_idx, b);
    do_idle("R8", 1);
    do_done("R8", a);
    chk("R8", "issue_idx", issue_idx, c);
    do_idle("R8", 1);
    flush("R8");

    // R10: squashed dependent's slot reused; producer completion leaves it alone
    do_ins("R10", 3, 0, 0, 0, 0, a);
    do_ins("R10", 3, 0, 0, 0, 0, e);
    do_ins("R10", 0, 0, N'(1) << a, 0, 1, b);
    squash_mask = N'(1) << b; tick("R10");
    do_ins("R10", 0, 0, N'(1) << e, 0, 1, c);
    chk("R10", "reuse_idx", c, b);
    do_done("R10", a);
    chk("R10", "issue_valid", issue_valid, 0);
    do_done("R10", e);
    chk("R10", "issue_idx", issue_idx, c);
    do_idle("R10", 1);
    flush("R10");

    // R11: one completion wakes three entries, issued lowest first
    do_ins("R11", 3, 0, 0, 0, 0, a);
    do_ins("R11", 1, 0, 0, N'(1) << a, 1, b);
    do_ins("R11", 1, 0, 0, N'(1) << a, 1, c);
    do_ins("R11", 2, 0, N'(1) << a, 0, 1, d);
    do_done("R11", a);
    chk("R11", "issue_idx", issue_idx, b);
    tick("R11");
    chk("R11", "issue_idx", issue_idx, c);
    tick("R11");
    chk("R11", "issue_idx", issue_idx, d);
    tick("R11");
    flush("R11");

    // R1: full table ignores ins_valid
    for (int i = 0; i < N; i++) do_ins("R1", 3, 0, 0, 0, 0, a);
    chk("R1", "ins_ready", ins_ready, 0);
    ins_valid = 1; ins_seq = 16'h7777; ins_regs_rdy = 1; tick("R1");
    chk("R1", "issue_valid", issue_valid, 0);
    flush("R1");

    // constrained random mix
    void'($urandom(32'h5eed_1234));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit [N-1:0] vm;
      vm = m_valid;
      ins_valid = ($urandom % 3) != 0;
      ins_kind = 2'($urandom % 4);
      ins_seq = SW'(seq_ctr);
      if (ins_valid && (~&m_valid)) begin
        seq_ctr++;
        if (seq_ctr >= 65535) seq_ctr = 1;
      end
      ins_regs_rdy = $urandom % 2;
      ins_ld_bar = (($urandom % 3) == 0) ? (N'($urandom) & (vm | N'($urandom % 2))) : '0;
      ins_st_bar = (($urandom % 3) == 0) ? (N'($urandom) & vm) : '0;
      case ($urandom % 3)
        0: ins_pred_seq = 0;
        1: ins_pred_seq = SW'(m_seq[$urandom % N]);
        default: ins_pred_seq = SW'($urandom % 65536);
      endcase
      rr_valid = ($urandom % 3) == 0; rr_idx = IW'($urandom % N);
      done_valid = ($urandom % 3) == 0; done_idx = IW'($urandom % N);
      squash_mask = (($urandom % 20) == 0) ? (N'($urandom) & vm) : '0;
      tick("R7");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule